// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM command bus. After reset it walks the memory through its mandatory start-up order before any traffic is allowed. First it holds clock enable high and drives only NOP for a stable-clock interval. It then closes every bank with a precharge-all and issues a configurable number of auto-refresh commands. Next it loads the mode register and, if enabled, the extended mode register. Once the recovery gap of the last mode command has elapsed, it raises a ready flag that hands the bus to the normal command scheduler.

Every gap is a clock-count parameter, and each gap is measured from one command to the next. A single down-counter times every gap, and a small tally counts the refreshes. The configuration inputs are read directly and must be held steady while the sequence runs. The FSM has ten states:

- `ST_STABLE`: the NOP hold after reset.
- `ST_PRECHARGE`, `ST_REFRESH`, `ST_LOAD_MODE` and `ST_LOAD_EXT`: one-cycle command issue states.
- `ST_WAIT_RP`, `ST_WAIT_RC`, `ST_WAIT_MODE` and `ST_WAIT_EXT`: the NOP gap after each command.
- `ST_READY`: the terminal state.

The transitions are:

- `ST_STABLE`→`ST_PRECHARGE` when the hold counter expires.
- `ST_PRECHARGE`→`ST_WAIT_RP`.
- `ST_WAIT_RP`→`ST_REFRESH` on expiry.
- `ST_REFRESH`→`ST_WAIT_RC`.
- `ST_WAIT_RC`→`ST_REFRESH` on expiry while the tally is short of its target.
- `ST_WAIT_RC`→`ST_LOAD_MODE` on expiry once the target is reached.
- `ST_LOAD_MODE`→`ST_WAIT_MODE`.
- `ST_WAIT_MODE`→`ST_LOAD_EXT` on expiry with the extended load enabled.
- `ST_WAIT_MODE`→`ST_READY` on expiry with the extended load disabled.
- `ST_LOAD_EXT`→`ST_WAIT_EXT`.
- `ST_WAIT_EXT`→`ST_READY` on expiry.
- `ST_READY` holds until reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low and for the first STABLE_CYC cycles after release (cycles t=0..STABLE_CYC-1, where t=0 is the cycle before the first rising edge after release), cke=1, the command {cs_n,ras_n,cas_n,we_n}=0111 (NOP), ba=0, addr=0 and ready=0. The default STABLE_CYC is 20000, which is 200 µs at 100 MHz.
- R2: At t=STABLE_CYC a precharge-all is driven: the command is 0010, addr has only bit 10 set, and ba=0.
- R3: Auto-refresh commands (0001, with ba=0 and addr=0) follow. Their number is refresh_cnt, or 2 when refresh_cnt is below 2. The first comes T_RP cycles after the precharge, and each further one comes T_RC cycles after the previous one.
- R4: A mode register load (command 0000, ba=00) comes T_RC cycles after the last refresh, with addr equal to mode_word masked as described in R6.
- R5: When ext_en=1, an extended mode load (command 0000, ba=10) comes T_MRD cycles after the mode load, with addr equal to ext_word masked as described in R6. In that word, bits 2..0 pick the refreshed array (000 full, 001 half, 010 quarter) and bits 6..5 pick the drive strength (00 full, 01 half).
- R6: Reserved bits are driven as 0. The mode load keeps only bits 9 and 6..0 of mode_word. The extended load keeps only bits 6..5 and 2..0 of ext_word.
- R7: ready goes high T_MRD cycles after the last mode command, is low before that, and stays high until reset.
- R8: Every cycle that R2 to R5 do not name drives NOP with ba=0 and addr=0, and so does every cycle from ready onward.
- R9: When ext_en=0, no extended mode load is issued; the memory then keeps its defaults of full drive strength and full-array refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sequence |
| mode_word | input | 13 | Mode register value |
| ext_word | input | 13 | Extended mode register value |
| ext_en | input | 1 | Issue the extended mode load when 1 |
| refresh_cnt | input | RCNT_W | Number of start-up refreshes (clamped to a minimum of 2) |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Address bus |
| ready | output | 1 | Initialization complete |

## Verification
A wrong state or a miscounted gap moves a command to another cycle. It can also repeat or drop a refresh, or show as a non-NOP value on the bus. Because the bench predicts the full 21-bit pin vector for every cycle after reset, any such slip is caught in the first cycle where the command lands wrongly. A bad mask or bank select shows on addr or ba in the very cycle of the mode command. A wrong exit from the terminal state shows as ready dropping or as a stray command one cycle later.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;

    // bits of each mode word that carry meaning; the rest are forced low
    localparam logic [ADDR_W-1:0] MODE_KEEP = 13'h027F;
    localparam logic [ADDR_W-1:0] EXT_KEEP  = 13'h0067;
    localparam logic [BA_W-1:0]   BA_MODE   = 2'b00;
    localparam logic [BA_W-1:0]   BA_EXT    = 2'b10;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP     = 4'b0111,
        CMD_PRECHG  = 4'b0010,
        CMD_REFRESH = 4'b0001,
        CMD_LOADMR  = 4'b0000
    } cmd_t;

    typedef enum logic [3:0] {
        ST_STABLE,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RC,
        ST_LOAD_MODE,
        ST_WAIT_MODE,
        ST_LOAD_EXT,
        ST_WAIT_EXT,
        ST_READY
    } state_t;

endpackage

// File: rtl/init_delay_ctr.sv
module init_delay_ctr #(
    parameter int CW      = 16,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/refresh_tally.sv
module refresh_tally #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic [RW-1:0] req_cnt,
    output logic          reached
);
    localparam logic [RW-1:0] MIN_REF = RW'(2);

    logic [RW-1:0] done_q;
    logic [RW-1:0] target;

    assign target = (req_cnt < MIN_REF) ? MIN_REF : req_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= '0;
        end else if (inc) begin
            done_q <= done_q + 1'b1;
        end
    end

    assign reached = (done_q >= target);
endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive
    import sdram_init_pkg::*;
(
    input  state_t            state,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic [ADDR_W-1:0] ext_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);
    cmd_t cmd;

    always_comb begin
        cmd   = CMD_NOP;
        ba    = '0;
        addr  = '0;
        ready = 1'b0;
        unique case (state)
            ST_PRECHARGE: begin
                cmd      = CMD_PRECHG;
                addr[10] = 1'b1;
            end
            ST_REFRESH:   cmd = CMD_REFRESH;
            ST_LOAD_MODE: begin
                cmd  = CMD_LOADMR;
                ba   = BA_MODE;
                addr = mode_word & MODE_KEEP;
            end
            ST_LOAD_EXT: begin
                cmd  = CMD_LOADMR;
                ba   = BA_EXT;
                addr = ext_word & EXT_KEEP;
            end
            ST_READY:     ready = 1'b1;
            ST_STABLE, ST_WAIT_RP, ST_WAIT_RC,
            ST_WAIT_MODE, ST_WAIT_EXT: cmd = CMD_NOP;
            default:      cmd = CMD_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int STABLE_CYC = 20000,
    parameter int T_RP       = 3,
    parameter int T_RC       = 7,
    parameter int T_MRD      = 2,
    parameter int RCNT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [12:0]       mode_word,
    input  logic [12:0]       ext_word,
    input  logic              ext_en,
    input  logic [RCNT_W-1:0] refresh_cnt,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [12:0]       addr,
    output logic              ready
);
    localparam int MAX_GAP = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                           : ((T_RP > T_MRD) ? T_RP : T_MRD);
    localparam int MAX_CNT = (STABLE_CYC > MAX_GAP) ? STABLE_CYC : MAX_GAP;
    localparam int CW      = $clog2(MAX_CNT + 1);

    state_t        state_q, state_d;
    logic          gap_zero;
    logic          gap_load;
    logic [CW-1:0] gap_val;
    logic          ref_done;

    init_delay_ctr #(.CW(CW), .RST_VAL(STABLE_CYC - 1)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    refresh_tally #(.RW(RCNT_W)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (state_q == ST_REFRESH),
        .req_cnt (refresh_cnt),
        .reached (ref_done)
    );

    // each command state arms the gap that follows it (gap minus issue cycle minus final cycle)
    always_comb begin
        gap_load = 1'b1;
        unique case (state_q)
            ST_PRECHARGE: gap_val = CW'(T_RP - 2);
            ST_REFRESH:   gap_val = CW'(T_RC - 2);
            ST_LOAD_MODE,
            ST_LOAD_EXT:  gap_val = CW'(T_MRD - 2);
            default: begin
                gap_load = 1'b0;
                gap_val  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STABLE:    if (gap_zero) state_d = ST_PRECHARGE;
            ST_PRECHARGE: state_d = ST_WAIT_RP;
            ST_WAIT_RP:   if (gap_zero) state_d = ST_REFRESH;
            ST_REFRESH:   state_d = ST_WAIT_RC;
            ST_WAIT_RC:   if (gap_zero) state_d = ref_done ? ST_LOAD_MODE : ST_REFRESH;
            ST_LOAD_MODE: state_d = ST_WAIT_MODE;
            ST_WAIT_MODE: if (gap_zero) state_d = ext_en ? ST_LOAD_EXT : ST_READY;
            ST_LOAD_EXT:  state_d = ST_WAIT_EXT;
            ST_WAIT_EXT:  if (gap_zero) state_d = ST_READY;
            ST_READY:     state_d = ST_READY;
            default:      state_d = ST_STABLE;
        endcase
    end

    assign cke = 1'b1;

    init_cmd_drive u_drive (
        .state     (state_q),
        .mode_word (mode_word),
        .ext_word  (ext_word),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .ready     (ready)
    );
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [1:0]  ba,
    input logic [12:0] addr,
    input logic        ready
);
    logic [3:0] cmd;
    assign cmd = {cs_n, ras_n, cas_n, we_n};

    assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_ready_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cmd == 4'b0111));

    assert_mode_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |=> (cmd == 4'b0111));

    assert_prechg_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> addr[10]);

    assert_refresh_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0001) |=> (cmd == 4'b0111));

    assert_mode_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000 && ba == 2'b00) |-> (addr[12:10] == 3'b000 && addr[8:7] == 2'b00));

    assert_ext_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000 && ba != 2'b00) |-> (ba == 2'b10 && addr[12:7] == 6'd0 && addr[4:3] == 2'd0));
endmodule

bind sdram_init_seq sdram_init_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .addr  (addr),
    .ready (ready)
);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;
    localparam int S     = 40;
    localparam int TRP   = 3;
    localparam int TRC   = 7;
    localparam int TMRD  = 2;
    localparam int RW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [12:0]   mode_word = '0;
    logic [12:0]   ext_word = '0;
    logic          ext_en = 1'b0;
    logic [RW-1:0] refresh_cnt = '0;
    logic          cke, cs_n, ras_n, cas_n, we_n, ready;
    logic [1:0]    ba;
    logic [12:0]   addr;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic seed_dummy;

    always #5 clk = ~clk;

    sdram_init_seq #(.STABLE_CYC(S), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .RCNT_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .ext_word(ext_word),
        .ext_en(ext_en), .refresh_cnt(refresh_cnt), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .ready(ready)
    );

    function automatic int n_ref(input logic [RW-1:0] rc);
        return (rc < 2) ? 2 : int'(rc);
    endfunction

    function automatic int ready_at(input logic en, input logic [RW-1:0] rc);
        int m;
        m = S + TRP + n_ref(rc) * TRC;
        return en ? m + 2 * TMRD : m + TMRD;
    endfunction

    // packed {cke, cs_n, ras_n, cas_n, we_n, ba, addr, ready}
    function automatic logic [20:0] expect_at(input int t, input logic [12:0] mw,
            input logic [12:0] ew, input logic en, input logic [RW-1:0] rc);
        int r0, m;
        logic [3:0]  c;
        logic [1:0]  b;
        logic [12:0] a;
        logic        rd;
        r0 = S + TRP;
        m  = r0 + n_ref(rc) * TRC;
        c = 4'b0111; b = 2'b00; a = '0; rd = 1'b0;
        if (t == S) begin
            c = 4'b0010; a = 13'h0400;
        end else if (t >= r0 && t < m && ((t - r0) % TRC) == 0) begin
            c = 4'b0001;
        end else if (t == m) begin
            c = 4'b0000; a = mw & 13'h027F;
        end else if (en && t == m + TMRD) begin
            c = 4'b0000; b = 2'b10; a = ew & 13'h0067;
        end
        if (t >= ready_at(en, rc)) rd = 1'b1;
        return {1'b1, c, b, a, rd};
    endfunction

    function automatic string tag_at(input int t, input logic [12:0] mw,
            input logic en, input logic [RW-1:0] rc);
        int r0, m;
        r0 = S + TRP;
        m  = r0 + n_ref(rc) * TRC;
        if (t < S) return "R1";
        if (t == S) return "R2";
        if (t < m) return "R3";
        if (t == m) return ((mw & ~13'h027F) != 0) ? "R6" : "R4";
        if (t == m + TMRD) return en ? "R5" : "R9";
        if (t >= ready_at(en, rc)) return "R7";
        return "R8";
    endfunction

    function automatic logic [20:0] pins();
        return {cke, cs_n, ras_n, cas_n, we_n, ba, addr, ready};
    endfunction

    task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp, input int t);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0d actual=%h expected=%h", tag, t, act, exp);
        end
    endtask

    task automatic run_one(input logic [12:0] mw, input logic [12:0] ew,
            input logic en, input logic [RW-1:0] rc);
        int last;
        @(negedge clk);
        rst_n = 1'b0;
        mode_word = mw; ext_word = ew; ext_en = en; refresh_cnt = rc;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1 check("R1", pins(), {1'b1, 4'b0111, 2'b00, 13'h0000, 1'b0}, -1);
        end
        @(negedge clk);
        rst_n = 1'b1;
        last = ready_at(en, rc) + 8;
        for (int t = 0; t <= last; t++) begin
            if (t != 0) @(negedge clk);
            #1 check(tag_at(t, mw, en, rc), pins(), expect_at(t, mw, ew, en, rc), t);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        seed_dummy = 1'($urandom(32'h1d2c));
        // directed: clamp of low counts, both ext settings, all-ones words (R6), array/drive codes (R5)
        run_one(13'h1FFF, 13'h1FFF, 1'b1, 4'd0);
        run_one(13'h0032, 13'h0001, 1'b0, 4'd1);
        run_one(13'h0233, 13'h0022, 1'b1, 4'd2);
        run_one(13'h1FFF, 13'h1FFF, 1'b0, 4'd3);
        run_one(13'h0000, 13'h0000, 1'b1, 4'd15);
        // random configurations
        for (int i = 0; i < 8; i++) begin
            run_one(13'($urandom), 13'($urandom), 1'($urandom), RW'($urandom));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule